// File: doc/BRIEF.md
# Reset Cause Flag Controller

This block takes every reset request in the chip and assigns it one of four kinds. The four kinds are a power-on reset, a reset from the external pin or from the brownout detector, a watchdog expiry while the core is running, and a watchdog expiry while the core sits in idle or sleep. It keeps two sticky status bits, a power-down flag and a time-out flag, and rewrites them according to that kind. Software reads these bits after restart to learn why the chip came back. A sleep-entry strobe and a watchdog-clear strobe also move the flags while no reset is in progress.

Alongside the flags, the block drives the reset strobes used by the rest of the chip. The program-counter low byte is cleared on every kind of reset, and the watchdog counter is restarted on every kind. The peripheral and interrupt control registers get their defaults on every kind except a watchdog wake from a low-power mode, which leaves them as they were. A two-bit code for the latest reset kind is presented together with a valid bit. The valid bit stays high for a configurable number of cycles after the reset ends, so that logic coming out of reset can still capture the code.

Top module: `reset_cause_ctrl`

## Requirements
- R1: While `pwr_on_rst_n` is low, both flags are 0, `rst_kind` is 0 (power-on), and `sys_rst`, `pc_clr`, `wdt_restart` and `ctrl_dflt` are all 1. The flags are cleared only by this input.
- R2: A clock edge that sees `ext_rst` or `brownout_rst` high sets `rst_kind` to 1 and leaves both flags unchanged.
- R3: A clock edge that sees only `wdt_timeout` high, with `lowpwr_mode` low, sets `rst_kind` to 2. It sets the time-out flag to 1 and leaves the power-down flag unchanged.
- R4: A clock edge that sees only `wdt_timeout` high, with `lowpwr_mode` high, sets `rst_kind` to 3 and sets both flags to 1.
- R5: When `ext_rst` or `brownout_rst` is high in the same cycle as `wdt_timeout`, the kind is 1 and the flags follow R2.
- R6: `pc_clr` and `wdt_restart` are high in every cycle that `sys_rst` is high, for every kind. `sys_rst` is high in the cycle after any edge that saw a reset source, and low in the cycle after an edge that saw none.
- R7: `ctrl_dflt` is high while `sys_rst` is high and `rst_kind` is 0, 1 or 2. It stays low while `rst_kind` is 3.
- R8: A clock edge with no reset source and `sleep_enter` high sets the power-down flag to 1 and clears the time-out flag. This holds even when `wdt_clear` is high in the same cycle.
- R9: A clock edge with no reset source, `wdt_clear` high and `sleep_enter` low clears both flags.
- R10: `kind_valid` is high while `sys_rst` is high and for TAIL_CYCLES (default 1) cycles after `sys_rst` falls, then low. `rst_kind` holds its value until the next reset source.
- R11: `sleep_enter` and `wdt_clear` have no effect on the flags on an edge where any reset source is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_on_rst_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst | input | 1 | External pin reset request |
| brownout_rst | input | 1 | Low-voltage reset request |
| wdt_timeout | input | 1 | Watchdog expiry request |
| lowpwr_mode | input | 1 | 1 while the core is in idle or sleep |
| sleep_enter | input | 1 | One-cycle strobe on entry to sleep |
| wdt_clear | input | 1 | One-cycle watchdog clear strobe |
| sys_rst | output | 1 | Core reset, high while a reset is in progress |
| pc_clr | output | 1 | Clear strobe for program-counter low byte |
| ctrl_dflt | output | 1 | Load defaults into peripheral and interrupt control registers |
| wdt_restart | output | 1 | Clear and restart the watchdog counter |
| pwrdn_flag | output | 1 | Sticky power-down flag |
| tmo_flag | output | 1 | Sticky time-out flag |
| rst_kind | output | 2 | 0 power-on, 1 pin/brownout, 2 watchdog running, 3 watchdog in low power |
| kind_valid | output | 1 | `rst_kind` is meaningful |

## Verification
Random cycles combine short bursts of each reset source with a random mode bit and random strobes. The watchdog bursts are split between running and low-power mode, which is the only input that separates kind 2 from kind 3 and tells whether the control registers are kept. Directed cases first set the flags through the strobes and then apply each reset kind. These cases show which flag each kind writes and which it keeps. They also apply a pin reset together with a watchdog expiry and a strobe, to test priority and strobe masking. A power-on pulse in the middle of the run, applied with both flags set, shows that only this input clears them, and the release of each reset shows the length of the valid tail.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

  typedef enum logic [1:0] {
    K_POWER_ON  = 2'd0,
    K_EXT       = 2'd1,
    K_WDOG_RUN  = 2'd2,
    K_WDOG_IDLE = 2'd3
  } rst_kind_e;

  // Priority among simultaneous sources: pin/brownout over watchdog.
  function automatic rst_kind_e classify(input logic ext_or_bo, input logic in_lowpwr);
    if (ext_or_bo)      return K_EXT;
    else if (in_lowpwr) return K_WDOG_IDLE;
    else                return K_WDOG_RUN;
  endfunction

  // Flag pair {power_down, time_out} after a reset of the given kind.
  function automatic logic [1:0] flags_after(input rst_kind_e k, input logic [1:0] cur);
    case (k)
      K_POWER_ON: return 2'b00;
      K_EXT:      return cur;
      K_WDOG_RUN: return {cur[1], 1'b1};
      default:    return 2'b11;
    endcase
  endfunction

  function automatic logic needs_ctrl_default(input rst_kind_e k);
    return k != K_WDOG_IDLE;
  endfunction

endpackage

// File: rtl/rcf_classify.sv
module rcf_classify
  import rcf_pkg::*;
(
  input  logic      ext_rst,
  input  logic      brownout_rst,
  input  logic      wdt_timeout,
  input  logic      lowpwr_mode,
  output logic      any_src,
  output rst_kind_e kind_now
);

  logic ext_or_bo;

  always_comb begin
    ext_or_bo = ext_rst | brownout_rst;
    any_src   = ext_or_bo | wdt_timeout;
    kind_now  = classify(ext_or_bo, lowpwr_mode);
  end

endmodule

// File: rtl/rcf_flags.sv
module rcf_flags
  import rcf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      any_src,
  input  rst_kind_e kind_now,
  input  logic      sleep_enter,
  input  logic      wdt_clear,
  output logic      pwrdn_flag,
  output logic      tmo_flag
);

  logic [1:0] flags_q;
  logic [1:0] flags_d;

  always_comb begin
    flags_d = flags_q;
    if (any_src)          flags_d = flags_after(kind_now, flags_q);
    else if (sleep_enter) flags_d = 2'b10;
    else if (wdt_clear)   flags_d = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= 2'b00;
    else        flags_q <= flags_d;
  end

  assign pwrdn_flag = flags_q[1];
  assign tmo_flag   = flags_q[0];

  // R2 and R11: a pin/brownout reset keeps both flags even when strobes arrive.
  p_ext_keeps_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (any_src && kind_now == K_EXT) |=> ($stable(pwrdn_flag) && $stable(tmo_flag)));

  // R3
  p_wdog_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (any_src && kind_now == K_WDOG_RUN) |=> (tmo_flag && $stable(pwrdn_flag)));

  // R4
  p_wdog_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_src && kind_now == K_WDOG_IDLE) |=> (tmo_flag && pwrdn_flag));

  // R8
  p_sleep_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_src && sleep_enter) |=> (pwrdn_flag && !tmo_flag));

  // R9
  p_wdt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_src && !sleep_enter && wdt_clear) |=> (!pwrdn_flag && !tmo_flag));

endmodule

// File: rtl/rcf_sequencer.sv
module rcf_sequencer
  import rcf_pkg::*;
#(
  parameter int TAIL_CYCLES = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      any_src,
  input  rst_kind_e kind_now,
  output logic      sys_rst,
  output rst_kind_e kind_q,
  output logic      kind_valid
);

  localparam int TW = $clog2(TAIL_CYCLES + 1);
  localparam logic [TW-1:0] TAIL_LOAD = TW'(TAIL_CYCLES);

  logic          active_q;
  logic [TW-1:0] tail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b1;
      kind_q   <= K_POWER_ON;
      tail_q   <= '0;
    end else if (any_src) begin
      active_q <= 1'b1;
      kind_q   <= kind_now;
      tail_q   <= '0;
    end else if (active_q) begin
      active_q <= 1'b0;
      tail_q   <= TAIL_LOAD;
    end else if (tail_q != '0) begin
      tail_q   <= tail_q - 1'b1;
    end
  end

  assign sys_rst    = active_q;
  assign kind_valid = active_q | (tail_q != '0);

  // R10: the code is still valid in the first cycle after reset ends.
  p_tail_after_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> kind_valid);

  // R10: with no new source the reported kind does not move.
  p_kind_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !any_src |=> $stable(kind_q));

  // R6: a source always leads to reset in the next cycle.
  p_src_starts_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any_src |=> sys_rst);

endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
  import rcf_pkg::*;
#(
  parameter int TAIL_CYCLES = 1
) (
  input  logic       clk,
  input  logic       pwr_on_rst_n,
  input  logic       ext_rst,
  input  logic       brownout_rst,
  input  logic       wdt_timeout,
  input  logic       lowpwr_mode,
  input  logic       sleep_enter,
  input  logic       wdt_clear,
  output logic       sys_rst,
  output logic       pc_clr,
  output logic       ctrl_dflt,
  output logic       wdt_restart,
  output logic       pwrdn_flag,
  output logic       tmo_flag,
  output logic [1:0] rst_kind,
  output logic       kind_valid
);

  logic      any_src;
  rst_kind_e kind_now;
  rst_kind_e kind_q;

  rcf_classify u_classify (
    .ext_rst      (ext_rst),
    .brownout_rst (brownout_rst),
    .wdt_timeout  (wdt_timeout),
    .lowpwr_mode  (lowpwr_mode),
    .any_src      (any_src),
    .kind_now     (kind_now)
  );

  rcf_flags u_flags (
    .clk         (clk),
    .rst_n       (pwr_on_rst_n),
    .any_src     (any_src),
    .kind_now    (kind_now),
    .sleep_enter (sleep_enter),
    .wdt_clear   (wdt_clear),
    .pwrdn_flag  (pwrdn_flag),
    .tmo_flag    (tmo_flag)
  );

  rcf_sequencer #(.TAIL_CYCLES(TAIL_CYCLES)) u_seq (
    .clk        (clk),
    .rst_n      (pwr_on_rst_n),
    .any_src    (any_src),
    .kind_now   (kind_now),
    .sys_rst    (sys_rst),
    .kind_q     (kind_q),
    .kind_valid (kind_valid)
  );

  assign pc_clr      = sys_rst;
  assign wdt_restart = sys_rst;
  assign ctrl_dflt   = sys_rst & needs_ctrl_default(kind_q);
  assign rst_kind    = kind_q;

  // R7 with R4: a low-power watchdog wake keeps control registers and has both flags set.
  p_idle_wake_keeps_ctrl_r7: assert property (@(posedge clk) disable iff (!pwr_on_rst_n)
    (sys_rst && kind_q == K_WDOG_IDLE) |-> (!ctrl_dflt && pwrdn_flag && tmo_flag));

  // R1: power-on holds everything in its reset state.
  always @(posedge clk) begin
    if (!pwr_on_rst_n)
      p_power_on_state_r1: assert (!pwrdn_flag && !tmo_flag && sys_rst && ctrl_dflt
                                   && rst_kind == 2'd0);
  end

endmodule

// File: tb/tb_reset_cause_ctrl.sv
module tb_reset_cause_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 4000;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  logic pwr_on_rst_n = 1'b1;
  logic ext_rst = 0, brownout_rst = 0, wdt_timeout = 0, lowpwr_mode = 0;
  logic sleep_enter = 0, wdt_clear = 0;
  logic sys_rst, pc_clr, ctrl_dflt, wdt_restart, pwrdn_flag, tmo_flag, kind_valid;
  logic [1:0] rst_kind;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  bit done     = 0;

  // Model state
  bit       m_rst;
  bit [1:0] m_kind;
  bit       m_pd, m_to;
  int       m_tail;
  string    flag_tag, kind_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_cause_ctrl dut (
    .clk(clk), .pwr_on_rst_n(pwr_on_rst_n), .ext_rst(ext_rst),
    .brownout_rst(brownout_rst), .wdt_timeout(wdt_timeout),
    .lowpwr_mode(lowpwr_mode), .sleep_enter(sleep_enter), .wdt_clear(wdt_clear),
    .sys_rst(sys_rst), .pc_clr(pc_clr), .ctrl_dflt(ctrl_dflt),
    .wdt_restart(wdt_restart), .pwrdn_flag(pwrdn_flag), .tmo_flag(tmo_flag),
    .rst_kind(rst_kind), .kind_valid(kind_valid)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // Expected kind code from the requirement encodings.
  function automatic bit [1:0] exp_kind(input bit eb, input bit lp);
    if (eb) return 2'd1;
    return lp ? 2'd3 : 2'd2;
  endfunction

  task automatic model_por();
    m_rst = 1; m_kind = 0; m_pd = 0; m_to = 0; m_tail = 0;
    flag_tag = "R1"; kind_tag = "R1";
  endtask

  task automatic model_step();
    bit eb, any;
    eb  = ext_rst | brownout_rst;
    any = eb | wdt_timeout;
    if (any) begin
      m_kind = exp_kind(eb, lowpwr_mode);
      case (m_kind)
        2'd1: begin flag_tag = (sleep_enter | wdt_clear) ? "R11" : "R2"; end
        2'd2: begin m_to = 1; flag_tag = "R3"; end
        default: begin m_to = 1; m_pd = 1; flag_tag = "R4"; end
      endcase
      kind_tag = (eb && wdt_timeout) ? "R5" : flag_tag;
      m_rst = 1; m_tail = 0;
    end else begin
      if (sleep_enter)    begin m_pd = 1; m_to = 0; flag_tag = "R8"; end
      else if (wdt_clear) begin m_pd = 0; m_to = 0; flag_tag = "R9"; end
      if (m_rst) begin m_rst = 0; m_tail = 1; end
      else if (m_tail > 0) m_tail--;
      kind_tag = "R10";
    end
  endtask

  task automatic check_all();
    chk(flag_tag, "pwrdn_flag", int'(pwrdn_flag), int'(m_pd));
    chk(flag_tag, "tmo_flag",   int'(tmo_flag),   int'(m_to));
    chk(kind_tag, "rst_kind",   int'(rst_kind),   int'(m_kind));
    chk("R6",  "sys_rst",     int'(sys_rst),     int'(m_rst));
    chk("R6",  "pc_clr",      int'(pc_clr),      int'(m_rst));
    chk("R6",  "wdt_restart", int'(wdt_restart), int'(m_rst));
    chk("R7",  "ctrl_dflt",   int'(ctrl_dflt),   int'(m_rst && m_kind != 2'd3));
    chk("R10", "kind_valid",  int'(kind_valid),  int'(m_rst || m_tail > 0));
  endtask

  // Drive at negedge, model at posedge, check at next negedge.
  task automatic cycle(input bit e, input bit b, input bit w, input bit lp,
                       input bit sl, input bit cl);
    ext_rst = e; brownout_rst = b; wdt_timeout = w; lowpwr_mode = lp;
    sleep_enter = sl; wdt_clear = cl;
    @(posedge clk);
    #1 model_step();
    @(negedge clk);
    check_all();
  endtask

  task automatic power_on_pulse();
    ext_rst = 0; brownout_rst = 0; wdt_timeout = 0; sleep_enter = 0; wdt_clear = 0;
    pwr_on_rst_n = 1'b0;
    #1 model_por();
    check_all();                      // R1: asynchronous effect
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check_all();                    // R1: held
    end
    pwr_on_rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG_CYCLES && !done) begin
      n_fails++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240613));
    #1;
    @(negedge clk);
    power_on_pulse();
    cycle(0,0,0,0,0,0);               // R10 tail after power-on
    cycle(0,0,0,0,0,0);

    // R8 then R2: pin reset keeps pd=1,to=0
    cycle(0,0,0,0,1,1);
    cycle(1,0,0,0,0,0);
    cycle(0,0,0,0,0,0);
    cycle(0,0,0,0,0,0);
    // R9 then R3: watchdog running
    cycle(0,0,0,0,0,1);
    cycle(0,0,1,0,0,0);
    cycle(0,0,0,0,0,0);
    // R4: watchdog in low power, R7 ctrl kept
    cycle(0,0,1,1,0,0);
    cycle(0,0,1,1,0,0);
    cycle(0,0,0,1,0,0);
    cycle(0,0,0,0,0,0);
    // R5 + R11: brownout and watchdog together with strobes
    cycle(0,0,0,0,1,0);
    cycle(0,1,1,1,1,1);
    cycle(0,0,0,0,0,0);
    // R1: power-on mid-run with both flags set
    cycle(0,0,1,1,0,0);
    power_on_pulse();
    cycle(0,0,0,0,0,0);
    cycle(0,0,0,0,0,0);

    for (int i = 0; i < RAND_CYCLES; i++) begin
      int r;
      r = $urandom_range(0, 99);
      cycle(r < 4, r >= 4 && r < 7, (r >= 7 && r < 15) || r == 3,
            $urandom_range(0, 1) == 1,
            $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule